// File: doc/BRIEF.md
# Regulator Start-up and Fault Sequencer

This block is the digital supervisor of a step-down regulator. It decides when the power stage may switch, what reference the error loop tracks, and how the output is treated when the regulator is off. On enable, it holds the power stage idle while the bandgap reference settles. It then ramps a digital reference code from zero up to the regulation target. After that it hands over to steady running. Skip mode is forced for the whole ramp, so a pre-charged output is not pulled down. The oscillator is slowed while the feedback node sits near ground.

Losing the enable or seeing input undervoltage returns the block to the off phase straight away, and an output discharge switch closes. An over-temperature code above the trip point stops the power stage. The block restarts from the wake phase only after the temperature has fallen to the resume point. All delays, the ramp step, its pacing and the final code are parameters expressed in clock ticks and code units.

Top module: `buck_seq_top`

## Requirements
- R1: When `en_in` is low or `uv_flag` is high, the outputs show off at once in that same cycle: `dis_en`=1, `run_en`=0, `skip_force`=0, `ref_code`=0, `fdiv_sel`=0. They stay so until enable returns and undervoltage clears, and the next start begins at the wake phase.
- R2: On the first clock edge with enable high and no undervoltage, the block enters the wake phase. It remains there for exactly `WAKE_TICKS` cycles with `run_en`=0, `ref_code`=0 and `dis_en`=0, then enters the ramp.
- R3: In the ramp, `run_en`=1 and `skip_force`=1. `ref_code` starts at 0 and rises by `REF_STEP` every `STEP_TICKS` cycles, saturating at `REF_FINAL`. Every new ramp restarts from 0.
- R4: One cycle after `ref_code` reaches `REF_FINAL`, the run phase begins: `run_en`=1, `skip_force`=0, `ref_code` held at `REF_FINAL`.
- R5: `fdiv_sel` encodes 0 = nominal, 1 = one third, 2 = minimum. In the ramp it reads 1 while `fb_low` is high, provided `fb_low` was high on the edge that entered the ramp and has not been low since.
- R6: `fdiv_sel` reads 2 while `fb_low` is high in the run phase. It also reads 2 in the ramp when the condition of R5 does not hold.
- R7: A `temp_code` (unsigned, degrees) at or above `TRIP_C` for two consecutive cycles stops the regulator from the next cycle on. In that thermal-stop phase `run_en`=0, `skip_force`=0, `ref_code`=0, `dis_en`=0.
- R8: The thermal-stop phase persists while `temp_code` stays above `RESUME_C`. Once `temp_code` is at or below `RESUME_C`, the block returns two edges later to the wake phase and then to a fresh ramp from 0.
- R9: Synchronous active-high `rst` puts the block in the off phase: `dis_en`=1, `run_en`=0, `ref_code`=0.
- R10: Outside the ramp and run phases, `fdiv_sel` is 0 whatever `fb_low` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| en_in | input | 1 | Regulator enable request |
| uv_flag | input | 1 | Input supply below undervoltage threshold |
| temp_code | input | TEMP_W | Die temperature in degrees, unsigned |
| fb_low | input | 1 | Feedback below the short-circuit level |
| ref_code | output | REF_W | Reference code for the error loop |
| run_en | output | 1 | Power stage may switch |
| skip_force | output | 1 | Force pulse-skipping (start-up) |
| fdiv_sel | output | 2 | Oscillator divide: 0 nominal, 1 third, 2 minimum |
| dis_en | output | 1 | Output discharge switch on |

## Verification
The bench builds the block with `WAKE_TICKS`=5, `STEP_TICKS`=2, `REF_STEP`=3 and `REF_FINAL`=20. With these values the whole start sequence finishes within about twenty cycles. Because 20 is not a multiple of 3, the last step clips, which exercises saturation of the reference code. The thermal thresholds stay at 140 and 115 so that codes one degree either side of each threshold, and codes inside the hysteresis band, can be applied directly.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

    typedef enum logic [2:0] {
        PH_OFF  = 3'd0,
        PH_WAKE = 3'd1,
        PH_RAMP = 3'd2,
        PH_RUN  = 3'd3,
        PH_HOT  = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        FDIV_NORM  = 2'd0,
        FDIV_THIRD = 2'd1,
        FDIV_MIN   = 2'd2
    } fdiv_e;

    typedef struct packed {
        logic  run;
        logic  skip;
        logic  dis;
        fdiv_e fdiv;
    } ctl_t;

    // Oscillator divide choice for a phase and the feedback state.
    function automatic fdiv_e pick_fdiv(phase_e ph, logic fb_low, logic start_low);
        fdiv_e f;
        f = FDIV_NORM;
        if (fb_low) begin
            case (ph)
                PH_RAMP: f = start_low ? FDIV_THIRD : FDIV_MIN;
                PH_RUN:  f = FDIV_MIN;
                default: f = FDIV_NORM;
            endcase
        end
        return f;
    endfunction

    // Output controls; a missing enable overrides the phase.
    function automatic ctl_t decode_ctl(phase_e ph, logic en_ok, logic fb_low, logic start_low);
        ctl_t c;
        c.run  = 1'b0;
        c.skip = 1'b0;
        c.dis  = 1'b1;
        c.fdiv = FDIV_NORM;
        if (en_ok) begin
            c.run  = (ph == PH_RAMP) || (ph == PH_RUN);
            c.skip = (ph == PH_RAMP);
            c.dis  = (ph == PH_OFF);
            c.fdiv = pick_fdiv(ph, fb_low, start_low);
        end
        return c;
    endfunction

endpackage

// File: rtl/buck_seq_thermal.sv
module buck_seq_thermal #(
    parameter int TEMP_W   = 8,
    parameter int TRIP_C   = 140,
    parameter int RESUME_C = 115
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TEMP_W-1:0] temp_code,
    output logic              hot
);
    localparam logic [TEMP_W-1:0] TRIP_V   = TEMP_W'(TRIP_C);
    localparam logic [TEMP_W-1:0] RESUME_V = TEMP_W'(RESUME_C);

    // Hysteresis: set at or above trip, clear at or below resume.
    always_ff @(posedge clk) begin
        if (rst) begin
            hot <= 1'b0;
        end else if (temp_code >= TRIP_V) begin
            hot <= 1'b1;
        end else if (temp_code <= RESUME_V) begin
            hot <= 1'b0;
        end
    end
endmodule

// File: rtl/buck_seq_wake.sv
module buck_seq_wake #(
    parameter int WAKE_TICKS = 6000
) (
    input  logic clk,
    input  logic rst,
    input  logic count_en,
    output logic done
);
    localparam int CW = (WAKE_TICKS > 1) ? $clog2(WAKE_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(WAKE_TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !count_en) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = count_en && (cnt_q == LAST);
endmodule

// File: rtl/buck_seq_ramp.sv
module buck_seq_ramp #(
    parameter int REF_W      = 10,
    parameter int REF_STEP   = 1,
    parameter int REF_FINAL  = 640,
    parameter int STEP_TICKS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             hold,
    output logic [REF_W-1:0] code,
    output logic             at_final
);
    localparam int XW = REF_W + 1;
    localparam logic [REF_W-1:0] FINAL_V = REF_W'(REF_FINAL);
    localparam logic [XW-1:0]    FINAL_X = XW'(REF_FINAL);
    localparam logic [XW-1:0]    STEP_X  = XW'(REF_STEP);

    logic          step_now;
    logic [XW-1:0] sum_x;
    logic [REF_W-1:0] next_code;

    generate
        if (STEP_TICKS <= 1) begin : g_every
            assign step_now = active;
        end else begin : g_paced
            localparam int TW = $clog2(STEP_TICKS);
            localparam logic [TW-1:0] T_LAST = TW'(STEP_TICKS - 1);
            logic [TW-1:0] tick_q;
            always_ff @(posedge clk) begin
                if (rst || !active) begin
                    tick_q <= '0;
                end else if (tick_q == T_LAST) begin
                    tick_q <= '0;
                end else begin
                    tick_q <= tick_q + 1'b1;
                end
            end
            assign step_now = active && (tick_q == T_LAST);
        end
    endgenerate

    // Saturating increment toward the final code.
    always_comb begin
        sum_x = {1'b0, code} + STEP_X;
        next_code = (sum_x >= FINAL_X) ? FINAL_V : sum_x[REF_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
        end else if (active) begin
            if (step_now) begin
                code <= next_code;
            end
        end else if (!hold) begin
            code <= '0;
        end
    end

    assign at_final = (code == FINAL_V);
endmodule

// File: rtl/buck_seq_top.sv
module buck_seq_top
    import buck_seq_pkg::*;
#(
    parameter int REF_W      = 10,
    parameter int REF_FINAL  = 640,
    parameter int REF_STEP   = 1,
    parameter int STEP_TICKS = 16,
    parameter int WAKE_TICKS = 6000,
    parameter int TEMP_W     = 8,
    parameter int TRIP_C     = 140,
    parameter int RESUME_C   = 115
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_in,
    input  logic              uv_flag,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic              fb_low,
    output logic [REF_W-1:0]  ref_code,
    output logic              run_en,
    output logic              skip_force,
    output logic [1:0]        fdiv_sel,
    output logic              dis_en
);
    phase_e ph_q, ph_d;
    logic   en_ok;
    logic   hot;
    logic   wake_cnt_en, wake_done;
    logic   ramp_active, ramp_hold, at_final;
    logic   start_low_q;
    logic [REF_W-1:0] ramp_code;
    ctl_t   ctl;

    assign en_ok = en_in && !uv_flag;

    buck_seq_thermal #(
        .TEMP_W  (TEMP_W),
        .TRIP_C  (TRIP_C),
        .RESUME_C(RESUME_C)
    ) thermal_i (
        .clk      (clk),
        .rst      (rst),
        .temp_code(temp_code),
        .hot      (hot)
    );

    assign wake_cnt_en = (ph_q == PH_WAKE) && en_ok && !hot;

    buck_seq_wake #(
        .WAKE_TICKS(WAKE_TICKS)
    ) wake_i (
        .clk     (clk),
        .rst     (rst),
        .count_en(wake_cnt_en),
        .done    (wake_done)
    );

    assign ramp_active = (ph_q == PH_RAMP) && en_ok && !hot;
    assign ramp_hold   = (ph_q == PH_RUN) && en_ok;

    buck_seq_ramp #(
        .REF_W     (REF_W),
        .REF_STEP  (REF_STEP),
        .REF_FINAL (REF_FINAL),
        .STEP_TICKS(STEP_TICKS)
    ) ramp_i (
        .clk     (clk),
        .rst     (rst),
        .active  (ramp_active),
        .hold    (ramp_hold),
        .code    (ramp_code),
        .at_final(at_final)
    );

    // Phase sequencing; loss of enable wins over everything.
    always_comb begin
        ph_d = ph_q;
        if (!en_ok) begin
            ph_d = PH_OFF;
        end else begin
            case (ph_q)
                PH_OFF:  ph_d = PH_WAKE;
                PH_WAKE: ph_d = hot ? PH_HOT : (wake_done ? PH_RAMP : PH_WAKE);
                PH_RAMP: ph_d = hot ? PH_HOT : (at_final ? PH_RUN : PH_RAMP);
                PH_RUN:  ph_d = hot ? PH_HOT : PH_RUN;
                PH_HOT:  ph_d = hot ? PH_HOT : PH_WAKE;
                default: ph_d = PH_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_OFF;
        end else begin
            ph_q <= ph_d;
        end
    end

    // Feedback-low state captured on ramp entry; dropped once feedback rises.
    always_ff @(posedge clk) begin
        if (rst) begin
            start_low_q <= 1'b0;
        end else if ((ph_q == PH_WAKE) && (ph_d == PH_RAMP)) begin
            start_low_q <= fb_low;
        end else if ((ph_q != PH_RAMP) || !fb_low) begin
            start_low_q <= 1'b0;
        end
    end

    always_comb begin
        ctl        = decode_ctl(ph_q, en_ok, fb_low, start_low_q);
        run_en     = ctl.run;
        skip_force = ctl.skip;
        dis_en     = ctl.dis;
        fdiv_sel   = ctl.fdiv;
        ref_code   = ctl.run ? ramp_code : '0;
    end
endmodule

// File: rtl/buck_seq_chk.sv
module buck_seq_chk #(
    parameter int REF_W     = 10,
    parameter int REF_FINAL = 640,
    parameter int REF_STEP  = 1,
    parameter int TEMP_W    = 8,
    parameter int TRIP_C    = 140
) (
    input logic              clk,
    input logic              rst,
    input logic              en_in,
    input logic              uv_flag,
    input logic [TEMP_W-1:0] temp_code,
    input logic              fb_low,
    input logic [REF_W-1:0]  ref_code,
    input logic              run_en,
    input logic              skip_force,
    input logic [1:0]        fdiv_sel,
    input logic              dis_en
);
    assert_abort_outputs_R1: assert property (@(posedge clk) disable iff (rst)
        (!en_in || uv_flag) |-> (dis_en && !run_en && !skip_force && ref_code == '0));

    assert_skip_in_ramp_R3: assert property (@(posedge clk) disable iff (rst)
        skip_force |-> run_en);

    assert_ramp_monotone_R3: assert property (@(posedge clk) disable iff (rst)
        (skip_force && $past(skip_force)) |-> (ref_code >= $past(ref_code)));

    assert_ramp_step_R3: assert property (@(posedge clk) disable iff (rst)
        (skip_force && $past(skip_force)) |->
            ((int'(ref_code) - int'($past(ref_code))) <= REF_STEP));

    assert_ref_cap_R4: assert property (@(posedge clk) disable iff (rst)
        int'(ref_code) <= REF_FINAL);

    assert_run_entry_final_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(skip_force) && run_en) |-> (int'(ref_code) == REF_FINAL));

    assert_fdiv_code_R5: assert property (@(posedge clk) disable iff (rst)
        fdiv_sel != 2'd3);

    assert_third_ctx_R5: assert property (@(posedge clk) disable iff (rst)
        (fdiv_sel == 2'd1) |-> (skip_force && fb_low));

    assert_min_ctx_R6: assert property (@(posedge clk) disable iff (rst)
        (fdiv_sel == 2'd2) |-> (run_en && fb_low));

    assert_hot_trip_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && int'($past(temp_code)) >= TRIP_C && int'(temp_code) >= TRIP_C)
            |=> !run_en);

    assert_reset_off_R9: assert property (@(posedge clk)
        $past(rst) |-> (dis_en && !run_en && ref_code == '0));

    assert_quiet_fdiv_R10: assert property (@(posedge clk) disable iff (rst)
        !run_en |-> (fdiv_sel == 2'd0));
endmodule

bind buck_seq_top buck_seq_chk #(
    .REF_W    (REF_W),
    .REF_FINAL(REF_FINAL),
    .REF_STEP (REF_STEP),
    .TEMP_W   (TEMP_W),
    .TRIP_C   (TRIP_C)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .en_in     (en_in),
    .uv_flag   (uv_flag),
    .temp_code (temp_code),
    .fb_low    (fb_low),
    .ref_code  (ref_code),
    .run_en    (run_en),
    .skip_force(skip_force),
    .fdiv_sel  (fdiv_sel),
    .dis_en    (dis_en)
);

// File: tb/buck_seq_top_tb_top.sv
`timescale 1ns/1ps
module buck_seq_top_tb_top;
    localparam int REF_W = 10;
    localparam int NV    = 20;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en_in = 1'b0;
    logic             uv_flag = 1'b0;
    logic [7:0]       temp_code = 8'd25;
    logic             fb_low = 1'b0;
    logic [REF_W-1:0] ref_code;
    logic             run_en, skip_force, dis_en;
    logic [1:0]       fdiv_sel;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    buck_seq_top #(
        .REF_W(REF_W), .REF_FINAL(20), .REF_STEP(3), .STEP_TICKS(2),
        .WAKE_TICKS(5), .TEMP_W(8), .TRIP_C(140), .RESUME_C(115)
    ) dut_i (
        .clk(clk), .rst(rst), .en_in(en_in), .uv_flag(uv_flag),
        .temp_code(temp_code), .fb_low(fb_low), .ref_code(ref_code),
        .run_en(run_en), .skip_force(skip_force), .fdiv_sel(fdiv_sel),
        .dis_en(dis_en)
    );

    typedef struct packed {
        logic       en;
        logic       uv;
        logic [7:0] temp;
        logic       fb;
        logic [7:0] edges;
        logic       run;
        logic       skip;
        logic [9:0] refv;
        logic [1:0] fdiv;
        logic       dis;
        logic [3:0] req;
    } vec_t;

    // Inputs, edges to wait, then expected run/skip/ref/fdiv/dis.
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,8'd25, 1'b0,8'd3, 1'b0,1'b0,10'd0, 2'd0,1'b1,4'd1},  // R1 off
        '{1'b1,1'b0,8'd25, 1'b1,8'd5, 1'b0,1'b0,10'd0, 2'd0,1'b0,4'd2},  // R2 wake lasts 5
        '{1'b1,1'b0,8'd25, 1'b1,8'd1, 1'b1,1'b1,10'd0, 2'd1,1'b0,4'd5},  // R5 ramp entry, third
        '{1'b1,1'b0,8'd25, 1'b1,8'd2, 1'b1,1'b1,10'd3, 2'd1,1'b0,4'd3},  // R3 first step
        '{1'b1,1'b0,8'd25, 1'b0,8'd2, 1'b1,1'b1,10'd6, 2'd0,1'b0,4'd5},  // R5 fb rose
        '{1'b1,1'b0,8'd25, 1'b1,8'd2, 1'b1,1'b1,10'd9, 2'd2,1'b0,4'd6},  // R6 min in ramp
        '{1'b1,1'b0,8'd25, 1'b0,8'd8, 1'b1,1'b1,10'd20,2'd0,1'b0,4'd3},  // R3 saturated
        '{1'b1,1'b0,8'd25, 1'b0,8'd1, 1'b1,1'b0,10'd20,2'd0,1'b0,4'd4},  // R4 run
        '{1'b1,1'b0,8'd25, 1'b1,8'd1, 1'b1,1'b0,10'd20,2'd2,1'b0,4'd6},  // R6 short in run
        '{1'b1,1'b0,8'd139,1'b0,8'd3, 1'b1,1'b0,10'd20,2'd0,1'b0,4'd7},  // R7 below trip
        '{1'b1,1'b0,8'd140,1'b0,8'd2, 1'b0,1'b0,10'd0, 2'd0,1'b0,4'd7},  // R7 trip
        '{1'b1,1'b0,8'd120,1'b0,8'd4, 1'b0,1'b0,10'd0, 2'd0,1'b0,4'd8},  // R8 band holds
        '{1'b1,1'b0,8'd115,1'b0,8'd2, 1'b0,1'b0,10'd0, 2'd0,1'b0,4'd8},  // R8 wake again
        '{1'b1,1'b0,8'd115,1'b0,8'd5, 1'b1,1'b1,10'd0, 2'd0,1'b0,4'd8},  // R8 fresh ramp
        '{1'b1,1'b0,8'd115,1'b0,8'd4, 1'b1,1'b1,10'd6, 2'd0,1'b0,4'd3},  // R3 restart steps
        '{1'b1,1'b1,8'd115,1'b0,8'd0, 1'b0,1'b0,10'd0, 2'd0,1'b1,4'd1},  // R1 uv same cycle
        '{1'b1,1'b1,8'd115,1'b0,8'd1, 1'b0,1'b0,10'd0, 2'd0,1'b1,4'd1},  // R1 uv held
        '{1'b1,1'b0,8'd141,1'b0,8'd3, 1'b0,1'b0,10'd0, 2'd0,1'b0,4'd7},  // R7 hot in wake
        '{1'b0,1'b0,8'd141,1'b0,8'd0, 1'b0,1'b0,10'd0, 2'd0,1'b1,4'd1},  // R1 en low
        '{1'b0,1'b0,8'd141,1'b1,8'd2, 1'b0,1'b0,10'd0, 2'd0,1'b1,4'd10}  // R10 fb while off
    };

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input int r, input int s, input int rf,
                             input int f, input int d);
        check(tag, "run_en", int'(run_en), r);
        check(tag, "skip_force", int'(skip_force), s);
        check(tag, "ref_code", int'(ref_code), rf);
        check(tag, "fdiv_sel", int'(fdiv_sel), f);
        check(tag, "dis_en", int'(dis_en), d);
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R9: reset with enable held high stays off
        en_in = 1'b1;
        step(3);
        check_all("R9", 0, 0, 0, 0, 1);
        en_in = 1'b0;
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            en_in     = VECS[i].en;
            uv_flag   = VECS[i].uv;
            temp_code = VECS[i].temp;
            fb_low    = VECS[i].fb;
            step(int'(VECS[i].edges));
            check_all($sformatf("R%0d[row %0d]", VECS[i].req, i), int'(VECS[i].run),
                      int'(VECS[i].skip), int'(VECS[i].refv), int'(VECS[i].fdiv),
                      int'(VECS[i].dis));
        end

        // R4: full start to run
        temp_code = 8'd25; fb_low = 1'b0; en_in = 1'b1;
        step(30);
        check_all("R4", 1, 0, 20, 0, 0);

        // R9: reset in the run phase
        rst = 1'b1;
        step(1);
        check_all("R9", 0, 0, 0, 0, 1);
        rst = 1'b0;
        step(1);
        check_all("R2", 0, 0, 0, 0, 0);
        step(5);
        check_all("R3", 1, 1, 0, 0, 0);
        step(4);
        check_all("R3", 1, 1, 6, 0, 0);

        // R1: enable drop mid-ramp, then restart from the wake phase
        en_in = 1'b0;
        step(0);
        check_all("R1", 0, 0, 0, 0, 1);
        step(1);
        en_in = 1'b1;
        step(1);
        check_all("R1", 0, 0, 0, 0, 0);
        step(5);
        check_all("R3", 1, 1, 0, 0, 0);
        step(2);
        check_all("R3", 1, 1, 3, 0, 0);

        finish_run();
    end
endmodule